// File: doc/BRIEF.md
# Register-Stepped I2C Master Transmitter

This block is an I2C master transmit engine that a host processor sequences one bus step at a time through four byte-wide registers. Software asks for a Start condition, writes an address byte into the transmit buffer, writes further data bytes, and finally asks for a Stop condition. After each step has fully completed, the block raises a sticky interrupt flag. Software waits for that flag before it issues the next step.

Bus timing comes from one down-counter shared by all steps. The counter advances on two of the four phases of each internal instruction cycle, so it moves once every second clock. It reloads itself from a 7-bit value, and each SCL low phase and each SCL high phase lasts reload+1 counter steps. Both bus lines are open drain. An output of 1 on either enable port pulls that line low. The block also reads the real level of each line back, so it can sample the slave's acknowledge and wait while a slave stretches the clock.

When the acknowledge clock of a byte has finished, the counter stops and SCL is held low until software issues the next command. Register map: address 0 is control, address 1 is status, address 2 is the transmit buffer and address 3 is the baud reload.

Top module: `i2c_step_tx`

## Requirements
- R1: After reset both line enables are 0 (lines released), irq_o is 0, and the control and status registers read 0x00.
- R2: Writing control (address 0) with bit 0 set while idle pulls SDA low while SCL stays released. Bit 0 reads 1 until the step ends. When the step ends, SCL is pulled low, bit 0 reads 0 and the flag is set, and this happens no earlier than 2*(reload+1)-1 clocks after the write.
- R3: Writing the buffer (address 2) while idle sends its 8 bits on SDA, most significant bit first. During the byte, SDA changes only while SCL is driven low.
- R4: On the ninth SCL clock the master releases SDA and stores the level it samples into control bit 6. A value of 0 means acknowledged and 1 means not acknowledged.
- R5: The interrupt flag (status bit 0, mirrored on irq_o) is set at the end of the ninth clock of every byte and at the end of each Start and each Stop. It stays set until software writes status with bit 0 at 0. Writing a 1 to that bit leaves the flag set.
- R6: Writing control with bit 2 set while idle drives SDA low and SCL low, then releases SCL, and then releases SDA while SCL is high. Bit 2 reads 1 until the step ends. At the end both lines are released and the flag is set.
- R7: The baud register (address 3) keeps only bits [6:0], and bit 7 reads back as 0. With no clock stretching, every SCL high phase of a byte lasts exactly 2*(reload+1) clocks.
- R8: After a byte's acknowledge clock, SCL stays driven low and neither line changes until the next command is written.
- R9: While the master has released SCL but the line still reads low, the baud count is held. Once the line is high, the high phase lasts 2*reload+1 or 2*reload+2 clocks.
- R10: While a step is in progress (status bit 2 = 1), a buffer write or a control write that sets bit 0 or bit 2 is ignored. Such a write sets the collision flag (status bit 1), which clears when software writes status with bit 1 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 status, 2 buffer, 3 baud) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Sticky step-complete interrupt |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_i | input | 1 | Sampled SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach from the ports is clock stretching, because it only matters inside the short window after the master releases SCL on a particular clock. The bench slave model finds the acknowledge clock by counting rising SCL edges. It holds the line low before the master releases it and keeps it low well past the normal high time. The bench then measures the high time that follows against the 2*reload+1 to 2*reload+2 window. Collision writes are timed into the middle of a running byte. The bench then checks that the captured byte and the count of Start conditions are unchanged.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LO, ST_HI, ST_STOP_LO, ST_STOP_HI, ST_STOP_END
  } tx_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_BUF  = 2'd2;
  localparam logic [1:0] ADDR_BAUD = 2'd3;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 2;
  localparam int CTRL_ACK_BIT   = 6;
  localparam int STAT_IRQ_BIT   = 0;
  localparam int STAT_WCOL_BIT  = 1;
  localparam int STAT_BUSY_BIT  = 2;
endpackage

// File: rtl/i2c_phase_tick.sv
module i2c_phase_tick #(
  parameter int PHASES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (PHASES > 2) ? $clog2(PHASES) : 1;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ph_q <= '0;
    else if (ph_q == PW'(PHASES - 1))   ph_q <= '0;
    else                                ph_q <= ph_q + 1'b1;
  end

  // second and fourth phase of each cycle
  assign tick_o = ph_q[0];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int BAUD_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] reload_i,
  output logic              expire_o
);
  logic [BAUD_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= reload_i;
    else if (expire_o)        cnt_q <= reload_i;
    else if (run_i && tick_i) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/i2c_tx_fsm.sv
module i2c_tx_fsm import i2c_step_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_go_i,
  input  logic              stop_go_i,
  input  logic              byte_go_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              expire_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              in_start_o,
  output logic              in_stop_o,
  output logic              in_byte_o,
  output logic              done_o,
  output logic              ack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  tx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  idx_q;
  logic              last_bit;
  logic              wait_high;

  assign last_bit   = (idx_q == BIT_W'(DATA_W));
  assign wait_high  = (st_q == ST_HI) || (st_q == ST_STOP_HI);
  assign busy_o     = (st_q != ST_IDLE);
  assign in_start_o = (st_q == ST_START);
  assign in_byte_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign in_stop_o  = (st_q == ST_STOP_LO) || (st_q == ST_STOP_HI) || (st_q == ST_STOP_END);
  // counter frozen while a released SCL is still held low
  assign run_o      = busy_o && !(wait_high && !scl_i);
  assign done_o     = expire_i && ((st_q == ST_START) || (st_q == ST_STOP_END) ||
                                   ((st_q == ST_HI) && last_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sh_q     <= '0;
      idx_q    <= '0;
      ack_o    <= 1'b0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_go_i) begin
            sda_oe_o <= 1'b1;
            st_q     <= ST_START;
          end else if (byte_go_i) begin
            sh_q     <= data_i;
            idx_q    <= '0;
            scl_oe_o <= 1'b1;
            st_q     <= ST_LO;
          end else if (stop_go_i) begin
            scl_oe_o <= 1'b1;
            sda_oe_o <= 1'b1;
            st_q     <= ST_STOP_LO;
          end
        end
        ST_START: if (expire_i) begin
          scl_oe_o <= 1'b1;
          st_q     <= ST_IDLE;
        end
        ST_LO: begin
          // data set up one cycle after SCL fell; ack slot releases SDA
          sda_oe_o <= last_bit ? 1'b0 : ~sh_q[DATA_W-1];
          if (expire_i) begin
            scl_oe_o <= 1'b0;
            st_q     <= ST_HI;
          end
        end
        ST_HI: if (expire_i) begin
          scl_oe_o <= 1'b1;
          if (last_bit) begin
            ack_o <= sda_i;
            st_q  <= ST_IDLE;
          end else begin
            sh_q  <= sh_q << 1;
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_LO;
          end
        end
        ST_STOP_LO: if (expire_i) begin
          scl_oe_o <= 1'b0;
          st_q     <= ST_STOP_HI;
        end
        ST_STOP_HI: if (expire_i) begin
          sda_oe_o <= 1'b0;
          st_q     <= ST_STOP_END;
        end
        ST_STOP_END: if (expire_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_step_tx.sv
module i2c_step_tx import i2c_step_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 7,
  parameter int PHASES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  input  logic              scl_i,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic              tick, expire, run, busy, done, ack;
  logic              in_start, in_stop, in_byte;
  logic              start_req, stop_req, buf_wr, stat_wr;
  logic              start_go, stop_go, byte_go, collide;
  logic              irq_q, wcol_q;
  logic [BAUD_W-1:0] reload_q;
  logic [DATA_W-1:0] buf_q;

  assign start_req = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_START_BIT];
  assign stop_req  = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_STOP_BIT];
  assign buf_wr    = reg_we_i && (reg_addr_i == ADDR_BUF);
  assign stat_wr   = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign start_go  = start_req && !busy;
  assign stop_go   = stop_req && !start_req && !busy;
  assign byte_go   = buf_wr && !busy;
  assign collide   = busy && (start_req || stop_req || buf_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      wcol_q   <= 1'b0;
      reload_q <= '0;
      buf_q    <= '0;
    end else begin
      if (done)                                    irq_q <= 1'b1;
      else if (stat_wr && !reg_wdata_i[STAT_IRQ_BIT])  irq_q <= 1'b0;
      if (collide)                                 wcol_q <= 1'b1;
      else if (stat_wr && !reg_wdata_i[STAT_WCOL_BIT]) wcol_q <= 1'b0;
      if (reg_we_i && (reg_addr_i == ADDR_BAUD))   reload_q <= reg_wdata_i[BAUD_W-1:0];
      if (byte_go)                                 buf_q <= reg_wdata_i;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_START_BIT] = in_start;
        reg_rdata_o[CTRL_STOP_BIT]  = in_stop;
        reg_rdata_o[CTRL_ACK_BIT]   = ack;
      end
      ADDR_STAT: begin
        reg_rdata_o[STAT_IRQ_BIT]  = irq_q;
        reg_rdata_o[STAT_WCOL_BIT] = wcol_q;
        reg_rdata_o[STAT_BUSY_BIT] = busy;
      end
      ADDR_BUF:  reg_rdata_o = buf_q;
      default:   reg_rdata_o[BAUD_W-1:0] = reload_q;
    endcase
  end

  i2c_phase_tick #(.PHASES(PHASES)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  i2c_baud_cnt #(.BAUD_W(BAUD_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .load_i(start_go || stop_go || byte_go), .run_i(run),
    .reload_i(reload_q), .expire_o(expire)
  );

  i2c_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_go_i(start_go), .stop_go_i(stop_go), .byte_go_i(byte_go),
    .data_i(reg_wdata_i), .expire_i(expire), .scl_i(scl_i), .sda_i(sda_i),
    .run_o(run), .busy_o(busy), .in_start_o(in_start), .in_stop_o(in_stop),
    .in_byte_o(in_byte), .done_o(done), .ack_o(ack),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );
endmodule

// File: rtl/i2c_step_tx_chk.sv
module i2c_step_tx_chk import i2c_step_pkg::*; #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              scl_i,
  input logic              busy,
  input logic              in_byte,
  input logic              in_stop,
  input logic              wcol_q
);
  // R3
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_byte && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  // R5
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_addr_i == ADDR_STAT && !reg_wdata_i[STAT_IRQ_BIT])) |=> irq_o);

  // R10
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == ADDR_BUF) |=> wcol_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !reg_we_i) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

  // R9
  stretch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_byte && !scl_oe_o && !scl_i) |=> !scl_oe_o);

  // R6
  stop_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stop && $fell(sda_oe_o)) |-> !scl_oe_o);
endmodule

bind i2c_step_tx i2c_step_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .scl_i(scl_i), .busy(busy), .in_byte(in_byte), .in_stop(in_stop), .wcol_q(wcol_q)
);

// File: tb/i2c_step_tx_test.sv
`timescale 1ns/100ps
module i2c_step_tx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       stretch = 1'b0, slave_low = 1'b0, slave_nack = 1'b0;
  logic       scl_line, sda_line;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign scl_line = !(scl_oe | stretch);
  assign sda_line = !(sda_oe | slave_low);

  i2c_step_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .scl_oe_o(scl_oe), .scl_i(scl_line), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // ---- slave / bus monitor ----
  logic [7:0] byte_log [0:63];
  int   nbytes = 0, bitcnt = 0, start_cnt = 0, stop_cnt = 0, pos_cnt = 0;
  int   width_bad = 0, last_hi_w = 0, exp_hi = 0;
  bit   in_xfer = 0, hi_valid = 0, stretch_mode = 0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;
  logic [7:0] rx_sh = 8'h00;
  realtime hi_t = 0;

  always @(scl_line, sda_line) begin
    if (scl_line !== scl_prev) begin
      if (scl_line === 1'b1 && in_xfer) begin
        pos_cnt++;
        hi_t = $realtime;
        hi_valid = 1;
        if (bitcnt < 8) begin rx_sh = {rx_sh[6:0], sda_line}; bitcnt++; end
        else if (bitcnt == 8) bitcnt = 9;
      end else if (scl_line === 1'b0) begin
        if (hi_valid) begin
          last_hi_w = int'(($realtime - hi_t) / 5.0);
          if (!stretch_mode && last_hi_w != exp_hi) width_bad++;
        end
        hi_valid = 0;
        if (bitcnt == 8) slave_low = !slave_nack;
        else if (bitcnt == 9) begin
          slave_low = 1'b0;
          byte_log[nbytes % 64] = rx_sh;
          nbytes++;
          bitcnt = 0;
        end
      end
    end else if (sda_line !== sda_prev && scl_line === 1'b1 && rst_ni) begin
      if (sda_line === 1'b0) begin start_cnt++; in_xfer = 1; bitcnt = 0; hi_valid = 0; end
      else if (sda_line === 1'b1) begin stop_cnt++; in_xfer = 0; hi_valid = 0; end
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  // ---- helpers ----
  function automatic int hi_width(input int r);
    return 2 * (r + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string req, output int cyc);
    cyc = 0;
    while (!irq && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(req, int'(irq), 1);
  endtask

  task automatic set_baud(input int r);
    wr(2'd3, 8'(r));
    exp_hi = hi_width(r);
  endtask

  task automatic step_start(input int r);
    int c, s0;
    logic [7:0] d;
    s0 = start_cnt;
    wr(2'd0, 8'h01);
    rd(2'd0, d);
    chk("R2 start bit busy", int'(d[0]), 1);
    chk("R2 sda low scl high", int'({sda_oe, scl_oe}), 2);
    wait_irq("R2 start irq", c);
    chk("R2 start hold", int'(c >= 2 * r + 1), 1);
    chk("R2 start seen", start_cnt, s0 + 1);
    chk("R2 scl low after start", int'(scl_oe), 1);
    rd(2'd0, d);
    chk("R2 start bit clear", int'(d[0]), 0);
    wr(2'd1, 8'h00);
  endtask

  task automatic step_byte(input logic [7:0] v, input logic nack);
    int c, n0;
    logic [7:0] d;
    n0 = nbytes;
    slave_nack = nack;
    wr(2'd2, v);
    wait_irq("R5 byte irq", c);
    chk("R3 byte count", nbytes, n0 + 1);
    chk("R3 byte msb first", int'(byte_log[(nbytes - 1) % 64]), int'(v));
    rd(2'd0, d);
    chk("R4 ack status", int'(d[6]), int'(nack));
    wr(2'd1, 8'h00);
  endtask

  task automatic step_stop();
    int c, p0;
    logic [7:0] d;
    p0 = stop_cnt;
    wr(2'd0, 8'h04);
    rd(2'd0, d);
    chk("R6 stop bit busy", int'(d[2]), 1);
    wait_irq("R6 stop irq", c);
    chk("R6 stop seen", stop_cnt, p0 + 1);
    chk("R6 lines released", int'({scl_oe, sda_oe}), 0);
    rd(2'd0, d);
    chk("R6 stop bit clear", int'(d[2]), 0);
    wr(2'd1, 8'h00);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- main ----
  initial begin
    logic [7:0] d;
    int c, n0, s0, p0, wb0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R1 lines released", int'({scl_oe, sda_oe}), 0);
    chk("R1 irq low", int'(irq), 0);
    rd(2'd0, d); chk("R1 ctrl zero", int'(d), 0);
    rd(2'd1, d); chk("R1 status zero", int'(d), 0);

    // R7: bit 7 of baud dropped
    wr(2'd3, 8'h83);
    rd(2'd3, d);
    chk("R7 baud bits", int'(d), 3);
    exp_hi = hi_width(3);

    step_start(3);

    // byte with acknowledge, flag stickiness
    slave_nack = 1'b0;
    wr(2'd2, 8'hA5);
    wait_irq("R5 byte irq", c);
    chk("R3 byte A5", int'(byte_log[(nbytes - 1) % 64]), 8'hA5);
    rd(2'd0, d); chk("R4 ack 0", int'(d[6]), 0);
    chk("R7 high width", width_bad, 0);
    chk("R7 last high", last_hi_w, 8);
    repeat (20) @(negedge clk);
    chk("R5 irq sticky", int'(irq), 1);
    wr(2'd1, 8'h01);
    chk("R5 write 1 keeps", int'(irq), 1);
    wr(2'd1, 8'h00);
    chk("R5 write 0 clears", int'(irq), 0);

    // R8 hold after byte
    p0 = pos_cnt;
    repeat (60) @(negedge clk);
    chk("R8 scl held low", int'(scl_oe), 1);
    chk("R8 no scl edges", pos_cnt, p0);

    step_byte(8'h3C, 1'b1);

    // R10 collision during a byte
    n0 = nbytes; s0 = start_cnt;
    slave_nack = 1'b0;
    wr(2'd2, 8'h11);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h05);
    rd(2'd1, d);
    chk("R10 wcol set", int'(d[1]), 1);
    chk("R10 busy", int'(d[2]), 1);
    wait_irq("R10 irq", c);
    chk("R10 one byte", nbytes, n0 + 1);
    chk("R10 byte kept", int'(byte_log[(nbytes - 1) % 64]), 8'h11);
    chk("R10 no start", start_cnt, s0);
    wr(2'd1, 8'h00);
    rd(2'd1, d);
    chk("R10 wcol cleared", int'(d[1]), 0);

    // R9 stretch on the acknowledge clock
    stretch_mode = 1;
    slave_nack = 1'b0;
    wr(2'd2, 8'h5A);
    c = 0;
    while (!(bitcnt == 8 && !scl_line) && c < 2000) begin @(negedge clk); c++; end
    stretch = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 master waits", int'(irq), 0);
    stretch = 1'b0;
    wait_irq("R9 irq", c);
    chk("R9 high after stretch", int'(last_hi_w == 7 || last_hi_w == 8), 1);
    chk("R9 byte", int'(byte_log[(nbytes - 1) % 64]), 8'h5A);
    wr(2'd1, 8'h00);
    stretch_mode = 0;

    step_stop();

    // random transactions
    for (int t = 0; t < 8; t++) begin
      int r, nb;
      r = $urandom_range(0, 5);
      set_baud(r);
      wb0 = width_bad;
      step_start(r);
      nb = $urandom_range(1, 3);
      for (int b = 0; b < nb; b++) step_byte(8'($urandom), 1'($urandom));
      step_stop();
      chk("R7 random width", width_bad, wb0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule